// File: doc/BRIEF.md
# Nibble Command Register Decoder

This block sits behind a serial receiver that has already turned the line into bytes. Each byte is one command frame. The upper nibble `frm_data_i[7:4]` is a select code and the lower nibble `frm_data_i[3:0]` is the data. The select code chooses one 4-bit slice of a small register set, and the data nibble is written into that slice. Wider registers are therefore assembled one slice at a time.

The register set holds six fields:
- a 16-bit hold word;
- a 10-bit memory address, whose top two bits are the same storage as the low two bits of a 4-bit register-set pointer;
- a 4-bit command, which pulses a one-cycle valid strobe when written;
- a 4-bit analog read timeout;
- a 4-bit analog location.

The all-ones frame is not a write. It raises a one-cycle baud-relearn request. A control byte input locks the interface whenever it equals FF hex. While locked, the block ignores every frame and asserts a route signal that selects the amplifier path. The lock is evaluated again on every cycle.

Top module: `nib_cmd_decoder`

## Requirements
- R1: A frame with select 0, 1, 2 or 3 writes its data nibble into hold bits [3:0], [7:4], [11:8] or [15:12] respectively, and leaves the other hold bits unchanged.
- R2: Select 6 writes memory address bits [3:0] and select 7 writes bits [7:4]. Select 8 writes the 4-bit register-set pointer, and pointer bits [1:0] always read back as memory address bits [9:8].
- R3: Select 9 writes the command field. In the cycle where the new command value appears, `cmd_valid_o` is high for that one cycle only, unless another select-9 frame follows directly.
- R4: Select 10 writes the timeout field and select 11 writes the analog location field.
- R5: Frames with select 4, 5, 12, 13 or 14 change no output.
- R6: The frame FF hex raises `relearn_o` for exactly one cycle and changes no register. A select-15 frame with any other data nibble changes nothing.
- R7: While `ctrl_byte_i` equals FF hex, `locked_o` and `amp_route_o` are high and frames change no output. Any other control byte value releases the lock in that same cycle.
- R8: While `rst_ni` is low, every register field and both strobes are zero.
- R9: While `frm_valid_i` is low, the value on `frm_data_i` has no effect.
- R10: Register fields and strobes update on the first rising clock edge that samples `frm_valid_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | Frame present this cycle |
| frm_data_i | input | 8 | Frame: [7:4] select, [3:0] data |
| ctrl_byte_i | input | 8 | Control byte; FF hex locks the interface |
| hold_o | output | 16 | Data hold word |
| mem_addr_o | output | 10 | Memory / calibration address |
| rs_ptr_o | output | 4 | Register-set pointer |
| cmd_o | output | 4 | Command field |
| cmd_valid_o | output | 1 | One-cycle strobe on command write |
| timeout_o | output | 4 | Analog read timeout |
| aloc_o | output | 4 | Analog location |
| relearn_o | output | 1 | One-cycle baud relearn request |
| locked_o | output | 1 | Interface locked |
| amp_route_o | output | 1 | Output routed to the amplifier path |

## Verification
On every cycle, the assertions check the following:
- the decoded write enables are mutually exclusive;
- the registers stay frozen after any cycle with no write;
- a lock blocks all writes and strobes in the next cycle;
- a relearn or command strobe traces back to a matching accepted frame.

Only the bench's scenarios show the rest:
- that each select code reaches its own slice with the right data;
- the pointer and address aliasing;
- the handling of reserved and non-all-ones select-15 frames;
- that releasing the lock restores normal decoding.

It does this by sweeping all 256 frames unlocked, locked and then in a permuted order.

// File: rtl/nib_cmd_pkg.sv
package nib_cmd_pkg;
  typedef enum logic [3:0] {
    SEL_HOLD0  = 4'h0,
    SEL_HOLD1  = 4'h1,
    SEL_HOLD2  = 4'h2,
    SEL_HOLD3  = 4'h3,
    SEL_ADDR_L = 4'h6,
    SEL_ADDR_M = 4'h7,
    SEL_PTR    = 4'h8,
    SEL_CMD    = 4'h9,
    SEL_TMO    = 4'hA,
    SEL_ALOC   = 4'hB,
    SEL_SPECL  = 4'hF
  } sel_e;
endpackage

// File: rtl/nib_lock_ctrl.sv
module nib_lock_ctrl #(
  parameter int         CTRL_W    = 8,
  parameter logic [7:0] LOCK_CODE = 8'hFF
) (
  input  logic [CTRL_W-1:0] ctrl_byte_i,
  input  logic              frm_valid_i,
  output logic              locked_o,
  output logic              accept_o
);
  assign locked_o = (ctrl_byte_i == LOCK_CODE[CTRL_W-1:0]);
  assign accept_o = frm_valid_i & ~locked_o;
endmodule

// File: rtl/nib_frame_decode.sv
module nib_frame_decode
  import nib_cmd_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int HOLD_NIBS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [2*NIB_W-1:0] frame_i,
  output logic [HOLD_NIBS-1:0] hold_we_o,
  output logic               alo_we_o,
  output logic               amid_we_o,
  output logic               ptr_we_o,
  output logic               cmd_we_o,
  output logic               tmo_we_o,
  output logic               aloc_we_o,
  output logic               relearn_o
);
  logic [NIB_W-1:0] sel, dat;
  assign sel = frame_i[2*NIB_W-1:NIB_W];
  assign dat = frame_i[NIB_W-1:0];

  for (genvar i = 0; i < HOLD_NIBS; i++) begin : g_hold_dec
    assign hold_we_o[i] = accept_i && (sel == NIB_W'(i));
  end

  assign alo_we_o  = accept_i && (sel == NIB_W'(SEL_ADDR_L));
  assign amid_we_o = accept_i && (sel == NIB_W'(SEL_ADDR_M));
  assign ptr_we_o  = accept_i && (sel == NIB_W'(SEL_PTR));
  assign cmd_we_o  = accept_i && (sel == NIB_W'(SEL_CMD));
  assign tmo_we_o  = accept_i && (sel == NIB_W'(SEL_TMO));
  assign aloc_we_o = accept_i && (sel == NIB_W'(SEL_ALOC));
  // only the full all-ones frame is a relearn; other data on that select is dropped
  assign relearn_o = accept_i && (sel == NIB_W'(SEL_SPECL)) && (&dat);

  assert_we_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hold_we_o, alo_we_o, amid_we_o, ptr_we_o, cmd_we_o,
              tmo_we_o, aloc_we_o, relearn_o}));
endmodule

// File: rtl/nib_reg_bank.sv
module nib_reg_bank #(
  parameter int NIB_W       = 4,
  parameter int HOLD_NIBS   = 4,
  parameter int PTR_ALIAS_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NIB_W-1:0]       wdata_i,
  input  logic [HOLD_NIBS-1:0]   hold_we_i,
  input  logic                   alo_we_i,
  input  logic                   amid_we_i,
  input  logic                   ptr_we_i,
  input  logic                   cmd_we_i,
  input  logic                   tmo_we_i,
  input  logic                   aloc_we_i,
  input  logic                   relearn_i,
  output logic [HOLD_NIBS*NIB_W-1:0]         hold_o,
  output logic [2*NIB_W+PTR_ALIAS_W-1:0]     mem_addr_o,
  output logic [NIB_W-1:0]       rs_ptr_o,
  output logic [NIB_W-1:0]       cmd_o,
  output logic                   cmd_valid_o,
  output logic [NIB_W-1:0]       timeout_o,
  output logic [NIB_W-1:0]       aloc_o,
  output logic                   relearn_o
);
  logic [HOLD_NIBS*NIB_W-1:0] hold_q;
  logic [2*NIB_W-1:0]         addr_q;
  logic [NIB_W-1:0]           ptr_q, cmd_q, tmo_q, aloc_q;
  logic                       cmd_v_q, rl_q;
  logic                       any_we;

  for (genvar i = 0; i < HOLD_NIBS; i++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           hold_q[i*NIB_W +: NIB_W] <= '0;
      else if (hold_we_i[i]) hold_q[i*NIB_W +: NIB_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      ptr_q   <= '0;
      cmd_q   <= '0;
      tmo_q   <= '0;
      aloc_q  <= '0;
      cmd_v_q <= 1'b0;
      rl_q    <= 1'b0;
    end else begin
      if (alo_we_i)  addr_q[NIB_W-1:0]       <= wdata_i;
      if (amid_we_i) addr_q[2*NIB_W-1:NIB_W] <= wdata_i;
      if (ptr_we_i)  ptr_q  <= wdata_i;
      if (cmd_we_i)  cmd_q  <= wdata_i;
      if (tmo_we_i)  tmo_q  <= wdata_i;
      if (aloc_we_i) aloc_q <= wdata_i;
      cmd_v_q <= cmd_we_i;
      rl_q    <= relearn_i;
    end
  end

  // pointer low bits double as the upper address bits: one storage element
  assign mem_addr_o  = {ptr_q[PTR_ALIAS_W-1:0], addr_q};
  assign hold_o      = hold_q;
  assign rs_ptr_o    = ptr_q;
  assign cmd_o       = cmd_q;
  assign cmd_valid_o = cmd_v_q;
  assign timeout_o   = tmo_q;
  assign aloc_o      = aloc_q;
  assign relearn_o   = rl_q;

  assign any_we = (|hold_we_i) | alo_we_i | amid_we_i | ptr_we_i |
                  cmd_we_i | tmo_we_i | aloc_we_i;

  assert_idle_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(any_we) |-> ($stable(hold_q) && $stable(addr_q) && $stable(ptr_q) &&
                        $stable(cmd_q) && $stable(tmo_q) && $stable(aloc_q)));

  assert_cmd_pulse_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_v_q |-> (cmd_q == $past(wdata_i)));
endmodule

// File: rtl/nib_cmd_decoder.sv
module nib_cmd_decoder #(
  parameter int         NIB_W       = 4,
  parameter int         HOLD_NIBS   = 4,
  parameter int         PTR_ALIAS_W = 2,
  parameter logic [7:0] LOCK_CODE   = 8'hFF,
  localparam int        FRM_W       = 2 * NIB_W,
  localparam int        HOLD_W      = HOLD_NIBS * NIB_W,
  localparam int        ADDR_W      = 2 * NIB_W + PTR_ALIAS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic [FRM_W-1:0]  frm_data_i,
  input  logic [7:0]        ctrl_byte_i,
  output logic [HOLD_W-1:0] hold_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NIB_W-1:0]  rs_ptr_o,
  output logic [NIB_W-1:0]  cmd_o,
  output logic              cmd_valid_o,
  output logic [NIB_W-1:0]  timeout_o,
  output logic [NIB_W-1:0]  aloc_o,
  output logic              relearn_o,
  output logic              locked_o,
  output logic              amp_route_o
);
  logic                 accept;
  logic [HOLD_NIBS-1:0] hold_we;
  logic alo_we, amid_we, ptr_we, cmd_we, tmo_we, aloc_we, rl_req;

  nib_lock_ctrl #(.CTRL_W(8), .LOCK_CODE(LOCK_CODE)) u_lock (
    .ctrl_byte_i (ctrl_byte_i),
    .frm_valid_i (frm_valid_i),
    .locked_o    (locked_o),
    .accept_o    (accept)
  );

  nib_frame_decode #(.NIB_W(NIB_W), .HOLD_NIBS(HOLD_NIBS)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .frame_i   (frm_data_i),
    .hold_we_o (hold_we),
    .alo_we_o  (alo_we),
    .amid_we_o (amid_we),
    .ptr_we_o  (ptr_we),
    .cmd_we_o  (cmd_we),
    .tmo_we_o  (tmo_we),
    .aloc_we_o (aloc_we),
    .relearn_o (rl_req)
  );

  nib_reg_bank #(.NIB_W(NIB_W), .HOLD_NIBS(HOLD_NIBS), .PTR_ALIAS_W(PTR_ALIAS_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wdata_i     (frm_data_i[NIB_W-1:0]),
    .hold_we_i   (hold_we),
    .alo_we_i    (alo_we),
    .amid_we_i   (amid_we),
    .ptr_we_i    (ptr_we),
    .cmd_we_i    (cmd_we),
    .tmo_we_i    (tmo_we),
    .aloc_we_i   (aloc_we),
    .relearn_i   (rl_req),
    .hold_o      (hold_o),
    .mem_addr_o  (mem_addr_o),
    .rs_ptr_o    (rs_ptr_o),
    .cmd_o       (cmd_o),
    .cmd_valid_o (cmd_valid_o),
    .timeout_o   (timeout_o),
    .aloc_o      (aloc_o),
    .relearn_o   (relearn_o)
  );

  assign amp_route_o = locked_o;

  assert_lock_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(locked_o) |-> (!cmd_valid_o && !relearn_o && $stable(hold_o) &&
                         $stable(mem_addr_o) && $stable(rs_ptr_o) && $stable(cmd_o) &&
                         $stable(timeout_o) && $stable(aloc_o)));

  assert_relearn_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relearn_o |-> $past(frm_valid_i && (&frm_data_i) && !locked_o));

  assert_cmd_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(frm_valid_i && !locked_o &&
                          frm_data_i[FRM_W-1:NIB_W] == NIB_W'(4'h9)));
endmodule

// File: tb/sim_nib_cmd_decoder.sv
`timescale 1ns/1ps
module sim_nib_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frm_valid = 1'b0;
  logic [7:0]  frm_data = 8'h00;
  logic [7:0]  ctrl_byte = 8'h00;
  logic [15:0] hold;
  logic [9:0]  mem_addr;
  logic [3:0]  rs_ptr, cmd, timeout, aloc;
  logic        cmd_valid, relearn, locked, amp_route;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // expected state
  logic [15:0] e_hold;
  logic [7:0]  e_alo;
  logic [3:0]  e_ptr, e_cmd, e_tmo, e_aloc;
  bit          e_cv, e_rl;

  always #2 clk = ~clk;

  nib_cmd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frm_valid_i(frm_valid), .frm_data_i(frm_data),
    .ctrl_byte_i(ctrl_byte), .hold_o(hold), .mem_addr_o(mem_addr), .rs_ptr_o(rs_ptr),
    .cmd_o(cmd), .cmd_valid_o(cmd_valid), .timeout_o(timeout), .aloc_o(aloc),
    .relearn_o(relearn), .locked_o(locked), .amp_route_o(amp_route)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "hold", hold, e_hold);
    chk(tag, "mem_addr", 16'(mem_addr), 16'({e_ptr[1:0], e_alo}));
    chk(tag, "rs_ptr", 16'(rs_ptr), 16'(e_ptr));
    chk(tag, "cmd", 16'(cmd), 16'(e_cmd));
    chk(tag, "cmd_valid", 16'(cmd_valid), 16'(e_cv));
    chk(tag, "timeout", 16'(timeout), 16'(e_tmo));
    chk(tag, "aloc", 16'(aloc), 16'(e_aloc));
    chk(tag, "relearn", 16'(relearn), 16'(e_rl));
  endtask

  function automatic string tag_of(input logic [7:0] f, input bit lk);
    if (lk) return "R7";
    case (f[7:4])
      4'h0, 4'h1, 4'h2, 4'h3: return "R1";
      4'h6, 4'h7, 4'h8:       return "R2";
      4'h9:                   return "R3";
      4'hA, 4'hB:             return "R4";
      4'hF:                   return "R6";
      default:                return "R5";
    endcase
  endfunction

  task automatic model(input logic [7:0] f, input bit lk);
    e_cv = 0;
    e_rl = 0;
    if (!lk) begin
      case (f[7:4])
        4'h0, 4'h1, 4'h2, 4'h3: e_hold[f[5:4]*4 +: 4] = f[3:0];
        4'h6: e_alo[3:0] = f[3:0];
        4'h7: e_alo[7:4] = f[3:0];
        4'h8: e_ptr = f[3:0];
        4'h9: begin e_cmd = f[3:0]; e_cv = 1; end
        4'hA: e_tmo = f[3:0];
        4'hB: e_aloc = f[3:0];
        4'hF: e_rl = (f[3:0] == 4'hF);
        default: ;
      endcase
    end
  endtask

  // one frame, check after the capturing edge (R10), then an idle cycle with live data (R9)
  task automatic send(input logic [7:0] f, input bit lk);
    @(negedge clk);
    frm_valid = 1'b1;
    frm_data  = f;
    @(negedge clk);
    frm_valid = 1'b0;
    frm_data  = 8'h95;
    model(f, lk);
    chk_all(tag_of(f, lk));
    chk("R10", "locked", 16'(locked), 16'(lk));
    @(negedge clk);
    e_cv = 0;
    e_rl = 0;
    chk_all("R9");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    e_hold = '0; e_alo = '0; e_ptr = '0; e_cmd = '0; e_tmo = '0; e_aloc = '0;
    e_cv = 0; e_rl = 0;
    frm_valid = 1'b1;
    frm_data  = 8'h9C;
    repeat (3) @(negedge clk);
    chk_all("R8");
    frm_valid = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R8");

    // unlocked sweep, every frame
    ctrl_byte = 8'h7F;
    for (int i = 0; i < 256; i++) send(8'(i), 1'b0);

    // locked sweep
    ctrl_byte = 8'hFF;
    @(negedge clk);
    chk("R7", "locked", 16'(locked), 16'd1);
    chk("R7", "amp_route", 16'(amp_route), 16'd1);
    for (int i = 0; i < 256; i++) send(8'(i * 53 + 7), 1'b1);

    // release: lock re-evaluated immediately
    ctrl_byte = 8'hFE;
    @(negedge clk);
    chk("R7", "locked", 16'(locked), 16'd0);
    chk("R7", "amp_route", 16'(amp_route), 16'd0);
    for (int i = 0; i < 256; i++) send(8'(i * 37 + 11), 1'b0);

    // back-to-back command frames keep the strobe high with each value
    @(negedge clk);
    frm_valid = 1'b1;
    frm_data  = 8'h93;
    @(negedge clk);
    frm_data  = 8'h9A;
    chk("R3", "cmd_valid b2b1", 16'(cmd_valid), 16'd1);
    chk("R3", "cmd b2b1", 16'(cmd), 16'h3);
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R3", "cmd_valid b2b2", 16'(cmd_valid), 16'd1);
    chk("R3", "cmd b2b2", 16'(cmd), 16'hA);
    @(negedge clk);
    chk("R3", "cmd_valid end", 16'(cmd_valid), 16'd0);

    // lock toggled mid-stream: a frame in a locked cycle is dropped
    @(negedge clk);
    ctrl_byte = 8'hFF;
    frm_valid = 1'b1;
    frm_data  = 8'hB5;
    @(negedge clk);
    ctrl_byte = 8'h00;
    frm_data  = 8'hB6;
    chk("R7", "aloc locked", 16'(aloc), 16'(e_aloc));
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R4", "aloc unlocked", 16'(aloc), 16'h6);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule